// File: doc/BRIEF.md
# Fractional Clock Divider Control Register Bank

This block holds the control word for four fractional clock-divider channels and drives them. Each channel gets one byte of a 32-bit register. That byte carries a 6-bit fraction and a stop bit. The phase-tap generator downstream divides its parent clock by the ratio 18/fraction. The generator itself is not part of this block.

Software reaches the register through a simple single-cycle port. The port has a byte address, a write strobe and 32-bit data.

- The plain address (offset 0x0) loads the whole word.
- Three alias addresses change only the bits that are 1 in the write data:
  - offset 0x4 sets them;
  - offset 0x8 clears them;
  - offset 0xC inverts them.

These aliases let one channel be changed without disturbing the others. To retune a channel, software clears its six fraction bits and then sets the new value.

For every channel the block also gives three combinational signals:

- a run-status flag;
- a flag that marks a fraction outside the legal window;
- the final clock-enable. This enable stays low while the fraction is illegal, whatever the stop bit says.

Top module: `fdiv_ctrl_bank`

## Requirements
- R1: After synchronous reset every channel byte equals 0x92 (stop bit 1, fraction 18), so a read returns 0x92929292 and all enables, status flags and range flags are 0.
- R2: A write to offset 0x0 replaces the whole register with the write data, except bit 6 of each byte.
- R3: A write to offset 0x4 sets each register bit whose data bit is 1 and leaves all other bits unchanged.
- R4: A write to offset 0x8 clears each register bit whose data bit is 1 and leaves all other bits unchanged.
- R5: A write to offset 0xC inverts each register bit whose data bit is 1 and leaves all other bits unchanged.
- R6: Channel n occupies register bits [8n+7:8n]. Its fraction is bits [5:0] of that byte and appears on ch_frac[6n+5:6n].
- R7: Bit 7 of a channel byte is the stop bit. ch_enabled[n] is 1 exactly when that bit is 0.
- R8: ch_range_err[n] is 1 exactly when channel n's fraction is below 12 or above 35.
- R9: ch_clk_en[n] is 1 only when channel n's stop bit is 0 and its fraction lies in 12..35.
- R10: Bit 6 of every byte always reads 0, whatever is written to it through any address.
- R11: A read from offset 0x0, 0x4, 0x8 or 0xC returns the current register contents.
- R12: A write to any other byte address changes nothing, and a read from such an address returns 0.
- R13: A write takes effect at the clock edge where the strobe is sampled. The next read, and all channel outputs, show the new value with no extra cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| ch_frac | output | NUM_CH*6 | Fraction value of each channel |
| ch_enabled | output | NUM_CH | Stop bit clear, per channel |
| ch_range_err | output | NUM_CH | Fraction outside 12..35, per channel |
| ch_clk_en | output | NUM_CH | Final clock enable to the generator |

## Verification
Some properties are checked on every cycle:

- each alias operation leaves the bits it names in the stated state, one edge after the strobe;
- a cycle with no write, or with an unmapped write, leaves every byte unchanged;
- the reserved bit stays 0;
- a clock enable never goes high with an illegal fraction or a set stop bit.

Other behaviour can only be shown by the bench's scenarios:

- that whole values come out right through a chain of writes;
- lane isolation during a clear-then-set retune;
- the 11/12 and 35/36 boundaries of the range flag;
- read data from alias and unmapped addresses.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

    localparam int LANE_W    = 8;
    localparam int FRAC_W    = 6;
    localparam int FRAC_LO   = 12;
    localparam int FRAC_HI   = 35;
    localparam int FRAC_RST  = 18;
    localparam int OFS_LOAD  = 'h0;
    localparam int OFS_SET   = 'h4;
    localparam int OFS_CLR   = 'h8;
    localparam int OFS_TOG   = 'hC;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_LOAD,
        ACC_SET,
        ACC_CLR,
        ACC_TOG
    } acc_op_e;

    // one channel byte: stop bit, reserved bit, fraction
    typedef struct packed {
        logic              stop;
        logic              rsvd;
        logic [FRAC_W-1:0] frac;
    } lane_t;

    localparam lane_t LANE_RST  = '{stop: 1'b1, rsvd: 1'b0, frac: FRAC_W'(FRAC_RST)};
    localparam lane_t LANE_MASK = '{stop: 1'b1, rsvd: 1'b0, frac: {FRAC_W{1'b1}}};

    function automatic lane_t lane_apply(acc_op_e op, lane_t cur, lane_t d);
        lane_t r;
        case (op)
            ACC_LOAD: r = d;
            ACC_SET:  r = lane_t'(cur | d);
            ACC_CLR:  r = lane_t'(cur & ~d);
            ACC_TOG:  r = lane_t'(cur ^ d);
            default:  r = cur;
        endcase
        r.rsvd = 1'b0;
        return r;
    endfunction

    function automatic logic frac_legal(logic [FRAC_W-1:0] f);
        return (int'(f) >= FRAC_LO) && (int'(f) <= FRAC_HI);
    endfunction

endpackage

// File: rtl/fdiv_addr_dec.sv
module fdiv_addr_dec
    import fdiv_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    output logic              hit,
    output acc_op_e           op
);

    acc_op_e sel;

    always_comb begin
        hit = 1'b1;
        sel = ACC_NONE;
        case (int'(addr))
            OFS_LOAD: sel = ACC_LOAD;
            OFS_SET:  sel = ACC_SET;
            OFS_CLR:  sel = ACC_CLR;
            OFS_TOG:  sel = ACC_TOG;
            default:  hit = 1'b0;
        endcase
        op = we ? sel : ACC_NONE;
    end

endmodule

// File: rtl/fdiv_lane.sv
module fdiv_lane
    import fdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  acc_op_e           op,
    input  lane_t             wr,
    output lane_t             q,
    output logic [FRAC_W-1:0] frac,
    output logic              enabled,
    output logic              range_err,
    output logic              clk_en
);

    always_ff @(posedge clk) begin
        if (rst) q <= LANE_RST;
        else     q <= lane_apply(op, q, wr);
    end

    assign frac      = q.frac;
    assign enabled   = ~q.stop;
    assign range_err = ~frac_legal(q.frac);
    assign clk_en    = enabled & ~range_err;

    // R3
    set_bits_chk: assert property (@(posedge clk) disable iff (rst)
        op == ACC_SET |=> (q & $past(wr) & LANE_MASK) == ($past(wr) & LANE_MASK));

    // R4
    clr_bits_chk: assert property (@(posedge clk) disable iff (rst)
        op == ACC_CLR |=> (q & $past(wr)) == '0);

    // R5
    tog_bits_chk: assert property (@(posedge clk) disable iff (rst)
        op == ACC_TOG |=> (q ^ $past(q)) == ($past(wr) & LANE_MASK));

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        op == ACC_NONE |=> $stable(q));

    // R10
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        q.rsvd == 1'b0);

    // R9
    gate_safe_chk: assert property (@(posedge clk) disable iff (rst)
        clk_en |-> (!q.stop && q.frac >= FRAC_W'(FRAC_LO) && q.frac <= FRAC_W'(FRAC_HI)));

endmodule

// File: rtl/fdiv_ctrl_bank.sv
module fdiv_ctrl_bank
    import fdiv_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8,
    localparam int DATA_W = NUM_CH * LANE_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic                     bus_we,
    input  logic [DATA_W-1:0]        bus_wdata,
    output logic [DATA_W-1:0]        bus_rdata,
    output logic [NUM_CH*FRAC_W-1:0] ch_frac,
    output logic [NUM_CH-1:0]        ch_enabled,
    output logic [NUM_CH-1:0]        ch_range_err,
    output logic [NUM_CH-1:0]        ch_clk_en
);

    logic              hit;
    acc_op_e           op;
    logic [DATA_W-1:0] word_q;

    fdiv_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .we   (bus_we),
        .hit  (hit),
        .op   (op)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_lane
        lane_t lane_q;

        fdiv_lane u_lane (
            .clk       (clk),
            .rst       (rst),
            .op        (op),
            .wr        (lane_t'(bus_wdata[n*LANE_W +: LANE_W])),
            .q         (lane_q),
            .frac      (ch_frac[n*FRAC_W +: FRAC_W]),
            .enabled   (ch_enabled[n]),
            .range_err (ch_range_err[n]),
            .clk_en    (ch_clk_en[n])
        );

        assign word_q[n*LANE_W +: LANE_W] = lane_q;
    end

    assign bus_rdata = hit ? word_q : '0;

    // R12
    unmapped_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && !hit) |=> $stable(word_q));

    // R12
    unmapped_rd_chk: assert property (@(posedge clk) disable iff (rst)
        !hit |-> bus_rdata == '0);

    // R2
    load_word_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && int'(bus_addr) == OFS_LOAD) |=> word_q == ($past(bus_wdata) & {NUM_CH{LANE_MASK}}));

endmodule

// File: tb/fdiv_ctrl_bank_bench.sv
`timescale 1ns/1ps
module fdiv_ctrl_bank_bench;

    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [23:0] ch_frac;
    logic [3:0]  ch_enabled, ch_range_err, ch_clk_en;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    fdiv_ctrl_bank u_fdiv_ctrl_bank (
        .clk          (clk),
        .rst          (rst),
        .bus_addr     (bus_addr),
        .bus_we       (bus_we),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .ch_frac      (ch_frac),
        .ch_enabled   (ch_enabled),
        .ch_range_err (ch_range_err),
        .ch_clk_en    (ch_clk_en)
    );

    typedef struct packed {
        logic [7:0]  addr;
        logic [31:0] data;
        logic [31:0] expect_word;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{8'h00, 32'h12230C92, 32'h12230C92},  // R2 load
        '{8'h04, 32'h40800000, 32'h12A30C92},  // R3 set, R10 bit6 ignored
        '{8'h08, 32'h0000803F, 32'h12A30C80},  // R4 clear fraction of lane 0
        '{8'h04, 32'h00000023, 32'h12A30CA3},  // R6 set new fraction lane 0
        '{8'h0C, 32'hC0FF0001, 32'h921C0CA2},  // R5 toggle, R10
        '{8'h10, 32'hFFFFFFFF, 32'h921C0CA2},  // R12 unmapped
        '{8'h02, 32'h00000000, 32'h921C0CA2},  // R12 misaligned
        '{8'h00, 32'h7F7F7F7F, 32'h3F3F3F3F},  // R10 load, R8 fraction 63
        '{8'h00, 32'h0B240C23, 32'h0B240C23}   // R8 boundaries 11/36/12/35
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic check_outputs(logic [31:0] w);
        logic [23:0] f;
        logic [3:0]  en, er, ck;
        for (int c = 0; c < NCH; c++) begin
            logic [7:0] b;
            b = w[c*8 +: 8];
            f[c*6 +: 6] = b[5:0];
            en[c] = ~b[7];
            er[c] = (b[5:0] < 6'd12) || (b[5:0] > 6'd35);
            ck[c] = en[c] & ~er[c];
        end
        check("R6 frac",  {8'h0, ch_frac}, {8'h0, f});
        check("R7 enabled", {28'h0, ch_enabled}, {28'h0, en});
        check("R8 range", {28'h0, ch_range_err}, {28'h0, er});
        check("R9 clk_en", {28'h0, ch_clk_en}, {28'h0, ck});
    endtask

    task automatic bus_write(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = 8'h00; bus_wdata = '0;
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        check("R1 reset word", bus_rdata, 32'h92929292);
        check_outputs(32'h92929292);
        check("R1 clk_en off", {28'h0, ch_clk_en}, 32'h0);

        for (int i = 0; i < 9; i++) begin
            bus_write(VECS[i].addr, VECS[i].data);
            // R13 value visible right after the strobe edge
            check("R13 table word", bus_rdata, VECS[i].expect_word);
            check_outputs(VECS[i].expect_word);
        end

        // R11 alias reads return contents
        bus_addr = 8'h04; #1; check("R11 read set alias", bus_rdata, 32'h0B240C23);
        bus_addr = 8'h08; #1; check("R11 read clr alias", bus_rdata, 32'h0B240C23);
        bus_addr = 8'h0C; #1; check("R11 read tog alias", bus_rdata, 32'h0B240C23);
        // R12 unmapped read
        bus_addr = 8'h14; #1; check("R12 unmapped read", bus_rdata, 32'h0);
        bus_addr = 8'h00; #1;

        // R7 enable lane 1 by clearing only bit 15 via alias
        bus_write(8'h00, 32'h92929292);
        bus_write(8'h08, 32'h00008000);
        check("R7 lane1 run", bus_rdata, 32'h92921292);
        check("R9 lane1 clk", {28'h0, ch_clk_en}, 32'h2);
        // R4/R3 retune lane 1 to 12, other lanes untouched
        bus_write(8'h08, 32'h00003F00);
        check("R4 lane1 cleared", bus_rdata, 32'h92920092);
        check("R9 gate forced off", {28'h0, ch_clk_en}, 32'h0);
        bus_write(8'h04, 32'h00000C00);
        check("R3 lane1 set", bus_rdata, 32'h92920C92);
        check("R9 lane1 back on", {28'h0, ch_clk_en}, 32'h2);

        // R1 reset again mid-operation
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0; #1;
        check("R1 re-reset", bus_rdata, 32'h92929292);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule